// File: doc/BRIEF.md
# Polled Byte I/O Port Controller

This block sits on a processor's load/store bus and gives software access to one byte-wide input device and one byte-wide output device through four word registers. The registers occupy a reserved window at the top of the address space, and no memory answers there. Software polls a readiness flag in each direction before it moves data. For input, the flag means that a fresh byte is waiting. For output, the flag means that the device can take another byte.

The device side raises the flags. The input device presents a byte with a one-cycle strobe. The output device signals that it has finished with the last byte through an accept strobe. The processor side lowers the flags as a side effect of a data access: a load from the input data word, or a store to the output data word. Reads are combinational and appear in the same cycle as the request. Every side effect takes place on the following clock edge.

Top module: `mmio_poll_ctrl`

## Requirements
- R1: After synchronous reset, the input flag (input control bit 0) is 0, the overrun flag (input control bit 1) is 0, the output flag (output control bit 0) is 1, both data words read 0, and `out_dev_valid` is 0.
- R2: `bus_hit` is 1 only when `bus_valid` is 1 and `bus_addr[31:16]` equals 16'hFFFF. `bus_rdata` is 0 whenever `bus_hit` is 0, during a write, or for any offset other than 0x0 (input control), 0x4 (input data), 0x8 (output control) and 0xC (output data). Unused bits of the register words read 0.
- R3: When `in_dev_valid` is 1 while the input flag is 0, the byte is latched into the input data word and the input flag reads 1 from the next cycle.
- R4: A load from offset 0x4 returns the stored byte in bits 7:0. On the next edge it clears the input flag and the overrun flag.
- R5: A byte presented while the input flag is 1, with no input data load in the same cycle, is dropped: the input data word keeps its value and the overrun flag becomes 1.
- R6: A store to offset 0xC while the output flag is 1 drives `bus_wdata[7:0]` onto `out_dev_byte` with `out_dev_valid` high for exactly the next cycle. It also clears the output flag, and the output data word reads back that byte.
- R7: A store to offset 0xC while the output flag is 0 has no effect: there is no pulse, and the flag and the data word are unchanged.
- R8: `out_dev_accept` while the output flag is 0 sets the flag on the next edge. While the flag is 1, `out_dev_accept` has no effect.
- R9: Stores to offsets 0x0 and 0x8 leave every flag unchanged.
- R10: A byte that arrives in the same cycle as an input data load is accepted: the data word takes the new byte and the input flag stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus request present this cycle |
| bus_write | input | 1 | 1 = store, 0 = load |
| bus_addr | input | 32 | Byte address of the request |
| bus_wdata | input | 32 | Store data; only bits 7:0 reach the output device |
| bus_hit | output | 1 | Request falls inside the I/O window |
| bus_rdata | output | 32 | Load data, combinational |
| in_dev_valid | input | 1 | Input device presents a byte (one cycle per byte) |
| in_dev_byte | input | 8 | Byte from the input device |
| out_dev_valid | output | 1 | One-cycle pulse carrying a new byte to the output device |
| out_dev_byte | output | 8 | Byte sent to the output device |
| out_dev_accept | input | 1 | Output device can take the next byte |

## Verification
The assertions assume that each device strobe lasts only one cycle per event. They also assume that the bus presents at most one request per cycle and holds it for just that one cycle. Under those conditions, every flag change follows from a single strobe or access. The directed tasks drive each strobe and each bus access for exactly one clock, starting on the falling edge. The tasks pair a device strobe with a bus access in the same cycle only in the scenario for R10.

// File: rtl/mmio_pkg.sv
package mmio_pkg;

    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int BYTE_W = 8;
    localparam int OFF_W  = 16;

    localparam logic [OFF_W-1:0] OFF_IN_CTRL  = 16'h0000;
    localparam logic [OFF_W-1:0] OFF_IN_DATA  = 16'h0004;
    localparam logic [OFF_W-1:0] OFF_OUT_CTRL = 16'h0008;
    localparam logic [OFF_W-1:0] OFF_OUT_DATA = 16'h000C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_CTRL,
        SEL_IN_DATA,
        SEL_OUT_CTRL,
        SEL_OUT_DATA
    } reg_sel_e;

    typedef struct packed {
        logic              valid;
        logic              write;
        logic [ADDR_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } dec_t;

    function automatic reg_sel_e offset_to_sel(input logic [OFF_W-1:0] off);
        case (off)
            OFF_IN_CTRL:  return SEL_IN_CTRL;
            OFF_IN_DATA:  return SEL_IN_DATA;
            OFF_OUT_CTRL: return SEL_OUT_CTRL;
            OFF_OUT_DATA: return SEL_OUT_DATA;
            default:      return SEL_NONE;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] widen(input logic [BYTE_W-1:0] b);
        return {{(WORD_W-BYTE_W){1'b0}}, b};
    endfunction

endpackage

// File: rtl/mmio_decode.sv
module mmio_decode
    import mmio_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hFFFF_0000
) (
    input  bus_req_t req,
    output dec_t     dec
);
    localparam int TAG_W = ADDR_W - OFF_W;

    logic in_win;

    always_comb begin
        in_win  = req.valid && (req.addr[ADDR_W-1:OFF_W] == WIN_BASE[ADDR_W-1:OFF_W]);
        dec.hit = in_win;
        dec.sel = in_win ? offset_to_sel(req.addr[OFF_W-1:0]) : SEL_NONE;
    end

    if (TAG_W < 1) begin : g_bad_width
        initial $error("window tag width must be positive");
    end
endmodule

// File: rtl/mmio_in_chan.sv
module mmio_in_chan
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              dev_valid,
    input  logic [BYTE_W-1:0] dev_byte,
    input  logic              take,
    output logic              rdy,
    output logic              ovr,
    output logic [BYTE_W-1:0] data
);
    logic accept_byte;
    logic drop_byte;

    always_comb begin
        accept_byte = dev_valid && (!rdy || take);
        drop_byte   = dev_valid && rdy && !take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy  <= 1'b0;
            ovr  <= 1'b0;
            data <= '0;
        end else begin
            if (accept_byte) begin
                data <= dev_byte;
                rdy  <= 1'b1;
            end else if (take) begin
                rdy  <= 1'b0;
            end
            if (drop_byte)
                ovr <= 1'b1;
            else if (take)
                ovr <= 1'b0;
        end
    end

    // R3
    arrival_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_valid && !rdy) |=> (rdy && data == $past(dev_byte)));

    // R4
    take_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (take && !dev_valid) |=> (!rdy && !ovr));

    // R5
    drop_keeps_data_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_valid && rdy && !take) |=> ($stable(data) && ovr && rdy));

    // R10
    coincident_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_valid && take) |=> (rdy && data == $past(dev_byte)));
endmodule

// File: rtl/mmio_out_chan.sv
module mmio_out_chan
    import mmio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              put,
    input  logic [BYTE_W-1:0] put_byte,
    input  logic              dev_accept,
    output logic              rdy,
    output logic [BYTE_W-1:0] data,
    output logic              dev_valid
);
    logic launch;

    always_comb launch = put && rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy       <= 1'b1;
            data      <= '0;
            dev_valid <= 1'b0;
        end else begin
            dev_valid <= launch;
            if (launch) begin
                data <= put_byte;
                rdy  <= 1'b0;
            end else if (dev_accept && !rdy) begin
                rdy  <= 1'b1;
            end
        end
    end

    // R6
    pulse_busy_chk: assert property (@(posedge clk) disable iff (rst)
        dev_valid |-> !rdy);

    // R6
    pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
        dev_valid |=> !dev_valid);

    // R7
    busy_store_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (put && !rdy) |=> (!dev_valid && $stable(data)));

    // R8
    accept_sets_rdy_chk: assert property (@(posedge clk) disable iff (rst)
        (dev_accept && !rdy) |=> rdy);
endmodule

// File: rtl/mmio_poll_ctrl.sv
module mmio_poll_ctrl
    import mmio_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'hFFFF_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_valid,
    input  logic        bus_write,
    input  logic [31:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic        bus_hit,
    output logic [31:0] bus_rdata,
    input  logic        in_dev_valid,
    input  logic [7:0]  in_dev_byte,
    output logic        out_dev_valid,
    output logic [7:0]  out_dev_byte,
    input  logic        out_dev_accept
);
    bus_req_t          req;
    dec_t              dec;
    logic              in_take;
    logic              out_put;
    logic              in_rdy;
    logic              in_ovr;
    logic [BYTE_W-1:0] in_data;
    logic              out_rdy;
    logic [BYTE_W-1:0] out_data;

    always_comb begin
        req.valid = bus_valid;
        req.write = bus_write;
        req.addr  = bus_addr;
        req.wdata = bus_wdata;
    end

    mmio_decode #(.WIN_BASE(WIN_BASE)) u_dec (
        .req (req),
        .dec (dec)
    );

    always_comb begin
        in_take = dec.hit && !req.write && (dec.sel == SEL_IN_DATA);
        out_put = dec.hit &&  req.write && (dec.sel == SEL_OUT_DATA);
    end

    mmio_in_chan u_in (
        .clk       (clk),
        .rst       (rst),
        .dev_valid (in_dev_valid),
        .dev_byte  (in_dev_byte),
        .take      (in_take),
        .rdy       (in_rdy),
        .ovr       (in_ovr),
        .data      (in_data)
    );

    mmio_out_chan u_out (
        .clk        (clk),
        .rst        (rst),
        .put        (out_put),
        .put_byte   (req.wdata[BYTE_W-1:0]),
        .dev_accept (out_dev_accept),
        .rdy        (out_rdy),
        .data       (out_data),
        .dev_valid  (out_dev_valid)
    );

    always_comb begin
        bus_hit   = dec.hit;
        bus_rdata = '0;
        if (dec.hit && !req.write) begin
            case (dec.sel)
                SEL_IN_CTRL:  bus_rdata = {{(WORD_W-2){1'b0}}, in_ovr, in_rdy};
                SEL_IN_DATA:  bus_rdata = widen(in_data);
                SEL_OUT_CTRL: bus_rdata = {{(WORD_W-1){1'b0}}, out_rdy};
                SEL_OUT_DATA: bus_rdata = widen(out_data);
                default:      bus_rdata = '0;
            endcase
        end
    end

    assign out_dev_byte = out_data;

    // R2
    miss_reads_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!bus_hit || bus_write) |-> (bus_rdata == 32'h0));

    // R9
    ctrl_store_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_hit && bus_write && (bus_addr[15:0] == 16'h0 || bus_addr[15:0] == 16'h8)
         && !in_dev_valid && !out_dev_accept) |=> ($stable(in_rdy) && $stable(out_rdy)));
endmodule

// File: tb/test_mmio_poll_ctrl.sv
module test_mmio_poll_ctrl;
    logic        clk = 1'b0;
    logic        rst;
    logic        bus_valid, bus_write;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_hit;
    logic [31:0] bus_rdata;
    logic        in_dev_valid;
    logic [7:0]  in_dev_byte;
    logic        out_dev_valid;
    logic [7:0]  out_dev_byte;
    logic        out_dev_accept;

    int checks = 0;
    int errors = 0;

    localparam logic [31:0] A_IC = 32'hFFFF_0000;
    localparam logic [31:0] A_ID = 32'hFFFF_0004;
    localparam logic [31:0] A_OC = 32'hFFFF_0008;
    localparam logic [31:0] A_OD = 32'hFFFF_000C;

    always #2 clk = ~clk;

    mmio_poll_ctrl i_mmio_poll_ctrl (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_hit(bus_hit), .bus_rdata(bus_rdata),
        .in_dev_valid(in_dev_valid), .in_dev_byte(in_dev_byte),
        .out_dev_valid(out_dev_valid), .out_dev_byte(out_dev_byte),
        .out_dev_accept(out_dev_accept)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
        in_dev_valid = 0; in_dev_byte = 0; out_dev_accept = 0;
    endtask

    // Reads combinationally; the access lasts one clock; returns the data seen.
    task automatic rd(input logic [31:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic push_in(input logic [7:0] b);
        @(negedge clk);
        in_dev_valid = 1; in_dev_byte = b;
        @(negedge clk);
        idle();
    endtask

    task automatic pulse_accept();
        @(negedge clk);
        out_dev_accept = 1;
        @(negedge clk);
        idle();
    endtask

    task automatic do_reset();
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(A_IC, d); chk("R1 in ctrl", d, 32'h0);
        rd(A_OC, d); chk("R1 out ctrl", d, 32'h1);
        rd(A_ID, d); chk("R1 in data", d, 32'h0);
        rd(A_OD, d); chk("R1 out data", d, 32'h0);
        chk("R1 out valid", {31'b0, out_dev_valid}, 32'h0);
    endtask

    task automatic t_decode();
        logic [31:0] d;
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = 32'hFFFE_0008;
        #1 chk("R2 miss hit", {31'b0, bus_hit}, 32'h0);
        chk("R2 miss data", bus_rdata, 32'h0);
        bus_addr = A_OC;
        #1 chk("R2 window hit", {31'b0, bus_hit}, 32'h1);
        bus_valid = 0;
        #1 chk("R2 no valid", {31'b0, bus_hit}, 32'h0);
        @(negedge clk); idle();
        rd(32'hFFFF_0010, d); chk("R2 unmapped", d, 32'h0);
        rd(32'hFFFF_0009, d); chk("R2 misaligned", d, 32'h0);
    endtask

    task automatic t_input();
        logic [31:0] d;
        push_in(8'hA5);
        rd(A_IC, d); chk("R3 ready set", d, 32'h1);
        rd(A_ID, d); chk("R4 data read", d, 32'hA5);
        rd(A_IC, d); chk("R4 ready cleared", d, 32'h0);
        rd(A_ID, d); chk("R4 data kept", d, 32'hA5);
        rd(A_IC, d); chk("R4 no re-set", d, 32'h0);
    endtask

    task automatic t_overrun();
        logic [31:0] d;
        push_in(8'h11);
        push_in(8'h22);
        rd(A_IC, d); chk("R5 overrun flag", d, 32'h3);
        rd(A_ID, d); chk("R5 data not overwritten", d, 32'h11);
        rd(A_IC, d); chk("R4 overrun cleared", d, 32'h0);
    endtask

    task automatic t_coincident();
        logic [31:0] d;
        push_in(8'h33);
        @(negedge clk);
        bus_valid = 1; bus_write = 0; bus_addr = A_ID;
        in_dev_valid = 1; in_dev_byte = 8'h44;
        #1 chk("R10 old byte returned", bus_rdata, 32'h33);
        @(negedge clk); idle();
        rd(A_IC, d); chk("R10 ready stays", d, 32'h1);
        rd(A_ID, d); chk("R10 new byte", d, 32'h44);
    endtask

    task automatic t_output();
        logic [31:0] d;
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = A_OD; bus_wdata = 32'hDEAD_BE5A;
        @(negedge clk); idle();
        chk("R6 pulse high", {31'b0, out_dev_valid}, 32'h1);
        chk("R6 byte", {24'b0, out_dev_byte}, 32'h5A);
        @(negedge clk);
        chk("R6 pulse one cycle", {31'b0, out_dev_valid}, 32'h0);
        rd(A_OC, d); chk("R6 ready cleared", d, 32'h0);
        rd(A_OD, d); chk("R6 readback", d, 32'h5A);
        @(negedge clk);
        bus_valid = 1; bus_write = 1; bus_addr = A_OD; bus_wdata = 32'h77;
        @(negedge clk); idle();
        chk("R7 no pulse", {31'b0, out_dev_valid}, 32'h0);
        rd(A_OD, d); chk("R7 data unchanged", d, 32'h5A);
        rd(A_OC, d); chk("R7 ready still 0", d, 32'h0);
        pulse_accept();
        rd(A_OC, d); chk("R8 ready set", d, 32'h1);
        pulse_accept();
        rd(A_OC, d); chk("R8 accept while ready", d, 32'h1);
        chk("R8 no pulse", {31'b0, out_dev_valid}, 32'h0);
    endtask

    task automatic t_ctrl_store();
        logic [31:0] d;
        wr(A_OC, 32'h0);
        rd(A_OC, d); chk("R9 out ready kept", d, 32'h1);
        wr(A_IC, 32'hFFFF_FFFF);
        rd(A_IC, d); chk("R9 in ready kept 0", d, 32'h0);
        push_in(8'h66);
        wr(A_IC, 32'h0);
        rd(A_IC, d); chk("R9 in ready kept 1", d, 32'h1);
        wr(A_ID, 32'h99);
        rd(A_IC, d); chk("R9 store to in data no clear", d, 32'h1);
        rd(A_ID, d); chk("R9 in data unchanged", d, 32'h66);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_decode();
        t_input();
        t_overrun();
        t_coincident();
        t_output();
        t_ctrl_store();
        do_reset();
        t_reset();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule